// File: doc/BRIEF.md
# Interrupt Pending and Active Tracker

This block keeps per-line interrupt state for a set of peripheral request lines and hands one of them at a time to a processor core. Each line owns a pending bit, an active bit and an enable bit. A pulse on a line's event input marks it pending. The block offers the lowest-numbered pending, enabled and idle line to the core through a request, accept and return handshake. When the core accepts, the line moves from pending to active. When the core returns, the active bit is dropped.

A line may be active and pending at once. An event that arrives while its handler runs is therefore kept as one pending re-entry. That re-entry is offered again as soon as the handler returns, so it is neither lost nor counted twice. Software reaches the enable bits through a small register port, and can also set or clear pending bits and read back the pending and active vectors. The scheme has a single level: while any line is active, no further entry is offered.

Top module: `irq_tracker_top`

## Requirements
- R1: After reset all enable, pending and active bits read zero and `coreReq` is low.
- R2: A one-cycle high on `evtIn[i]` sets pending bit i, and the pending bit is visible on the next cycle when reading address 1 or 2.
- R3: An accept while `coreReq` is high does two things in the same clock edge: it sets the active bit of line `coreLine` (read at address 3) and clears that line's pending bit. A pending read right after entry therefore shows zero for that line.
- R4: An event on a line that is active sets its pending bit again, so the line is both active and pending.
- R5: `coreReturn` clears the active bit and leaves every pending bit as it was. A line still pending is offered again on the cycle after the return.
- R6: Any number of events that arrive while a line is already pending merge into one request. After that single entry and its return, the line is not offered again.
- R7: If an event and an accept hit the same line in the same cycle, the line becomes active and stays pending.
- R8: If an event and a return hit the same line in the same cycle, active clears, pending is set, and `coreReq` with that line appears on the next cycle.
- R9: Writing a 1 to address 1 sets the matching pending bit, just as an event does. Writing a 1 to address 2 clears it, but a hardware event on that line in the same cycle keeps the bit set.
- R10: Only lines that are enabled (address 0, bit i), pending and not active are offered. Among several such lines, `coreLine` is the lowest index.
- R11: While any active bit is set, `coreReq` stays low, and at most one active bit is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | NUM_LINES | Per-line peripheral event, one-cycle pulse |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 enable, 1 pending set, 2 pending clear, 3 active (read-only) |
| regWrData | input | NUM_LINES | Register write data, one bit per line |
| regRdData | output | NUM_LINES | Read data for the selected register (addresses 1 and 2 both read pending) |
| coreReq | output | 1 | A line is offered to the core |
| coreLine | output | LINE_W | Index of the offered line |
| coreAccept | input | 1 | Core takes the offered line |
| coreReturn | input | 1 | Core finishes the active handler |

## Verification
The hardest cases to reach are the ones where an event lands on the same line in the same clock cycle as the accept or the return for that line. In those cycles the set and the clear of a state bit compete. The bench drives `evtIn` for exactly one edge, together with `coreAccept` or `coreReturn`. It then reads the pending and active vectors through the register port and checks whether the line is offered again on the following cycle. A similar collision is forced between a software clear-pending write and a hardware event.

// File: rtl/irq_tracker_pkg.sv
`timescale 1ns/1ps
package irq_tracker_pkg;
  typedef enum logic [1:0] {
    REG_ENABLE   = 2'd0,
    REG_PEND_SET = 2'd1,
    REG_PEND_CLR = 2'd2,
    REG_ACTIVE   = 2'd3
  } regSel_t;

  typedef struct packed {
    logic take;    // core accepted the offered line
    logic retire;  // core returned from the active handler
  } ctrlStb_t;
endpackage

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick #(
  parameter int NUM_LINES = 8,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0] candVec,
  output logic                 anyCand,
  output logic [LINE_W-1:0]    pickIdx
);
  always_comb begin
    pickIdx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (candVec[i]) pickIdx = LINE_W'(i);
    end
  end
  assign anyCand = |candVec;
endmodule

// File: rtl/irq_ctrl.sv
`timescale 1ns/1ps
module irq_ctrl
  import irq_tracker_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic [NUM_LINES-1:0] pendVec,
  input  logic [NUM_LINES-1:0] actVec,
  input  logic [NUM_LINES-1:0] enVec,
  input  logic                 coreAccept,
  input  logic                 coreReturn,
  output logic                 coreReq,
  output logic [LINE_W-1:0]    coreLine,
  output ctrlStb_t             stb
);
  logic [NUM_LINES-1:0] eligVec;
  logic                 anyElig;
  logic                 anyActive;

  assign eligVec   = pendVec & enVec & ~actVec;
  assign anyActive = |actVec;

  irq_prio_pick #(.NUM_LINES(NUM_LINES)) pick_i (
    .candVec(eligVec),
    .anyCand(anyElig),
    .pickIdx(coreLine)
  );

  // single level: nothing is offered while a handler is running
  assign coreReq    = anyElig && !anyActive;
  assign stb.take   = coreReq && coreAccept;
  assign stb.retire = coreReturn && anyActive;
endmodule

// File: rtl/irq_state.sv
`timescale 1ns/1ps
module irq_state
  import irq_tracker_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] evtIn,
  input  logic                 regWrEn,
  input  logic [1:0]           regAddr,
  input  logic [NUM_LINES-1:0] regWrData,
  output logic [NUM_LINES-1:0] regRdData,
  input  ctrlStb_t             stb,
  input  logic [LINE_W-1:0]    takeLine,
  output logic [NUM_LINES-1:0] pendVec,
  output logic [NUM_LINES-1:0] actVec,
  output logic [NUM_LINES-1:0] enVec
);
  regSel_t              sel;
  logic [NUM_LINES-1:0] swSet;
  logic [NUM_LINES-1:0] swClr;
  logic                 enWr;

  assign sel   = regSel_t'(regAddr);
  assign swSet = (regWrEn && sel == REG_PEND_SET) ? regWrData : '0;
  assign swClr = (regWrEn && sel == REG_PEND_CLR) ? regWrData : '0;
  assign enWr  = regWrEn && sel == REG_ENABLE;

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    logic hit;
    logic setPend;
    logic dropPend;

    assign hit      = stb.take && (takeLine == LINE_W'(g));
    assign setPend  = evtIn[g] || swSet[g];
    assign dropPend = hit || swClr[g];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendVec[g] <= 1'b0;
        actVec[g]  <= 1'b0;
        enVec[g]   <= 1'b0;
      end else begin
        // a new event always wins over any clear in the same cycle
        if (setPend)       pendVec[g] <= 1'b1;
        else if (dropPend) pendVec[g] <= 1'b0;

        if (hit)             actVec[g] <= 1'b1;
        else if (stb.retire) actVec[g] <= 1'b0;

        if (enWr) enVec[g] <= regWrData[g];
      end
    end
  end

  always_comb begin
    unique case (sel)
      REG_ENABLE:   regRdData = enVec;
      REG_PEND_SET: regRdData = pendVec;
      REG_PEND_CLR: regRdData = pendVec;
      REG_ACTIVE:   regRdData = actVec;
      default:      regRdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_tracker_top.sv
`timescale 1ns/1ps
module irq_tracker_top
  import irq_tracker_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] evtIn,
  input  logic                 regWrEn,
  input  logic [1:0]           regAddr,
  input  logic [NUM_LINES-1:0] regWrData,
  output logic [NUM_LINES-1:0] regRdData,
  output logic                 coreReq,
  output logic [LINE_W-1:0]    coreLine,
  input  logic                 coreAccept,
  input  logic                 coreReturn
);
  logic [NUM_LINES-1:0] pendVec;
  logic [NUM_LINES-1:0] actVec;
  logic [NUM_LINES-1:0] enVec;
  ctrlStb_t             stb;

  irq_ctrl #(.NUM_LINES(NUM_LINES)) ctrl_i (
    .pendVec(pendVec), .actVec(actVec), .enVec(enVec),
    .coreAccept(coreAccept), .coreReturn(coreReturn),
    .coreReq(coreReq), .coreLine(coreLine), .stb(stb)
  );

  irq_state #(.NUM_LINES(NUM_LINES)) state_i (
    .clk(clk), .rstN(rstN), .evtIn(evtIn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .stb(stb), .takeLine(coreLine),
    .pendVec(pendVec), .actVec(actVec), .enVec(enVec)
  );
endmodule

// File: rtl/irq_tracker_chk.sv
`timescale 1ns/1ps
module irq_tracker_chk #(
  parameter int NUM_LINES = 8,
  localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_LINES-1:0] evtIn,
  input logic                 regWrEn,
  input logic                 coreReq,
  input logic [LINE_W-1:0]    coreLine,
  input logic                 coreAccept,
  input logic                 coreReturn,
  input logic [NUM_LINES-1:0] pendVec,
  input logic [NUM_LINES-1:0] actVec,
  input logic [NUM_LINES-1:0] enVec
);
  logic [NUM_LINES-1:0] belowMask;
  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) belowMask[i] = (LINE_W'(i) < coreLine);
  end

  // R2
  evt_sets_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn != '0) |=> ((pendVec & $past(evtIn)) == $past(evtIn)));

  // R3
  take_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreReq && coreAccept && !evtIn[coreLine] && !regWrEn)
      |=> (!pendVec[$past(coreLine)] && actVec[$past(coreLine)]));

  // R7
  take_keeps_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreReq && coreAccept && evtIn[coreLine])
      |=> (pendVec[$past(coreLine)] && actVec[$past(coreLine)]));

  // R5
  ret_clears_act_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreReturn && (|actVec)) |=> (actVec == '0));

  // R5
  ret_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreReturn && (|actVec) && !regWrEn) |=> (($past(pendVec) & ~pendVec) == '0));

  // R11
  no_req_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|actVec) |-> !coreReq);

  // R11
  single_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(actVec));

  // R10
  lowest_pick_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreReq |-> (pendVec[coreLine] && enVec[coreLine]
                 && ((pendVec & enVec & ~actVec & belowMask) == '0)));
endmodule

bind irq_tracker_top irq_tracker_chk #(.NUM_LINES(NUM_LINES)) chk_i (
  .clk(clk), .rstN(rstN), .evtIn(evtIn), .regWrEn(regWrEn),
  .coreReq(coreReq), .coreLine(coreLine), .coreAccept(coreAccept),
  .coreReturn(coreReturn), .pendVec(pendVec), .actVec(actVec), .enVec(enVec)
);

// File: tb/irq_tracker_tb.sv
`timescale 1ns/1ps
module irq_tracker_top_tb_top;
  localparam int N = 8;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  evtIn = '0;
  logic          regWrEn = 1'b0;
  logic [1:0]    regAddr = 2'd0;
  logic [N-1:0]  regWrData = '0;
  logic [N-1:0]  regRdData;
  logic          coreReq;
  logic [LW-1:0] coreLine;
  logic          coreAccept = 1'b0;
  logic          coreReturn = 1'b0;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_tracker_top #(.NUM_LINES(N)) dut_i (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .coreReq(coreReq), .coreLine(coreLine),
    .coreAccept(coreAccept), .coreReturn(coreReturn)
  );

  task automatic check(input string req, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [N-1:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [N-1:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    step();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic pulse(input logic [N-1:0] e);
    evtIn = e;
    step();
    evtIn = '0;
  endtask

  task automatic acceptOne();
    coreAccept = 1'b1;
    step();
    coreAccept = 1'b0;
  endtask

  task automatic returnOne();
    coreReturn = 1'b1;
    step();
    coreReturn = 1'b0;
  endtask

  task automatic checkState(input string req, input int pend, input int act);
    logic [N-1:0] d;
    readReg(2'd1, d); check({req, " pending"}, int'(d), pend);
    readReg(2'd3, d); check({req, " active"}, int'(d), act);
  endtask

  task automatic checkReq(input string req, input bit exReq, input int exLine);
    #0.5;
    check({req, " coreReq"}, int'(coreReq), int'(exReq));
    if (exReq) check({req, " coreLine"}, int'(coreLine), exLine);
  endtask

  task automatic testReset();
    logic [N-1:0] d;
    readReg(2'd0, d); check("R1 enable", int'(d), 0);
    checkState("R1", 0, 0);
    checkReq("R1", 1'b0, 0);
  endtask

  task automatic testBasicFlow();
    writeReg(2'd0, 8'hFF);
    pulse(8'h08);
    checkState("R2", 8'h08, 0);
    checkReq("R2", 1'b1, 3);
    acceptOne();
    checkState("R3", 0, 8'h08);
    checkReq("R11", 1'b0, 0);
    pulse(8'h08);
    checkState("R4", 8'h08, 8'h08);
    pulse(8'h20);
    checkReq("R11 second line", 1'b0, 0);
    returnOne();
    checkState("R5", 8'h28, 0);
    checkReq("R10 lowest", 1'b1, 3);
    acceptOne(); returnOne();
    checkReq("R10 next", 1'b1, 5);
    acceptOne(); returnOne();
    checkReq("R5 drained", 1'b0, 0);
  endtask

  task automatic testCoalesce();
    pulse(8'h04); pulse(8'h04); pulse(8'h04);
    checkState("R6", 8'h04, 0);
    acceptOne(); returnOne();
    checkReq("R6 single entry", 1'b0, 0);
    checkState("R6 after", 0, 0);
  endtask

  task automatic testAcceptCollision();
    pulse(8'h02);
    checkReq("R7 offer", 1'b1, 1);
    evtIn = 8'h02; coreAccept = 1'b1;
    step();
    evtIn = '0; coreAccept = 1'b0;
    checkState("R7", 8'h02, 8'h02);
    returnOne();
    checkReq("R7 re-entry", 1'b1, 1);
    acceptOne(); returnOne();
    checkReq("R7 drained", 1'b0, 0);
  endtask

  task automatic testReturnCollision();
    pulse(8'h10);
    acceptOne();
    evtIn = 8'h10; coreReturn = 1'b1;
    step();
    evtIn = '0; coreReturn = 1'b0;
    checkState("R8", 8'h10, 0);
    checkReq("R8", 1'b1, 4);
    acceptOne(); returnOne();
    checkReq("R8 drained", 1'b0, 0);
  endtask

  task automatic testSoftware();
    writeReg(2'd1, 8'h40);
    checkState("R9 set", 8'h40, 0);
    checkReq("R9 set", 1'b1, 6);
    writeReg(2'd2, 8'h40);
    checkState("R9 clear", 0, 0);
    checkReq("R9 clear", 1'b0, 0);
    writeReg(2'd1, 8'h80);
    evtIn = 8'h80;
    writeReg(2'd2, 8'h80);
    evtIn = '0;
    checkState("R9 collision", 8'h80, 0);
    writeReg(2'd2, 8'h80);
    checkState("R9 cleanup", 0, 0);
  endtask

  task automatic testEnable();
    writeReg(2'd0, 8'h00);
    pulse(8'h01);
    checkReq("R10 masked", 1'b0, 0);
    checkState("R10 masked", 8'h01, 0);
    writeReg(2'd1, 8'h0C);
    writeReg(2'd0, 8'h0C);
    checkReq("R10 enabled subset", 1'b1, 2);
    writeReg(2'd0, 8'h0D);
    checkReq("R10 all", 1'b1, 0);
    writeReg(2'd2, 8'hFF);
    checkReq("R10 none", 1'b0, 0);
  endtask

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    testReset();
    testBasicFlow();
    testCoalesce();
    testAcceptCollision();
    testReturnCollision();
    testSoftware();
    testEnable();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule